// File: doc/BRIEF.md
# SCSI Controller Host Register Interface

This block is the processor-facing side of a SCSI bus controller. The host sees two byte locations. The address location takes a 5-bit index into a 32-entry register window, and reading it returns the auxiliary status byte. The data location reads or writes whichever register the index currently points at. After most data-location accesses the index steps forward on its own, so the host can stream through consecutive registers without reloading it.

Writing a byte to the command register runs a command. The commands are: software reset, assert attention (no action here), disconnect, select with or without attention, and select-and-transfer with or without attention. Select-and-transfer talks to a simple target port. The block raises a select strobe together with the target ID, and the target answers in the same cycle with accept, the phase it wants (status, data-in or data-out), the length of its first block and its status byte. In programmed-I/O data phases, every access to the data register moves one byte to or from the target. Each byte counts down the 24-bit transfer count and the per-block counter. When a block runs out, the block asks the target for the next one.

Reading the SCSI status register has side effects. After a finished transfer, the first read of the status moves the controller to the disconnected state. Any other status read clears the interrupt flag. The real bus timing, DMA and the target device itself lie outside the block.

Top module: `scsi_hostif`

## Requirements
- R1: A write to the address location (host_addr=0) loads the index from data bits 4:0, and a read there returns the auxiliary status. After a data-location access the index increments by one, except when the index is 0x18 (command), 0x19 (data) or 0x1F (auxiliary status); there it holds.
- R2: The 24-bit transfer count appears as three byte registers: 0x12 holds bits 23:16, 0x13 holds bits 15:8 and 0x14 holds bits 7:0. Each can be read, and a write replaces only its own byte.
- R3: A write to index 0x00 (own ID) stores the byte and drives own_id_o with bits 2:0 of it.
- R4: A command written while auxiliary bit 4 (command in progress) is set is ignored, and the command register keeps its old value.
- R5: Command 0x00 clears indices 0x01 to 0x1A and the transfer count, disconnects, and sets the index to 0. It then sets the status (index 0x17) to 0x01 if own-ID bit 3 is set, and to 0x00 otherwise. Disconnecting, which command 0x04 also does, ends any data phase and sets auxiliary status to 0x80 (bit 7 is the interrupt flag).
- R6: Commands 0x06 and 0x07 take the target ID from bits 2:0 of index 0x15 (shown on tgt_id_o). They set status 0x42 (selection timeout), clear the transfer count and set auxiliary status to 0x80.
- R7: Commands 0x08 and 0x09 raise tgt_sel_o only when no device is busy and the ID is below MAX_DEV (7). Without a select, or when the target rejects it, they give status 0x42, a cleared count and auxiliary status 0x80. If an accepted target returns a data phase (1 = in, 2 = out), auxiliary status becomes 0x31 (bits 5 busy, 4 in progress, 0 buffer ready). If it returns the status phase (0 or 3), index 0x0F takes the target status, status becomes 0x16 (transfer end) and the block disconnects.
- R8: An accepted 0x08 raises tgt_msg_vld_o in the select cycle with tgt_msg_o equal to index 0x0F with bit 7 set. An accepted 0x09 never raises tgt_msg_vld_o.
- R9: A status read while the status is 0x16 returns 0x16, then sets the status to 0x85 and auxiliary status to exactly 0x80. A status read of any other value clears auxiliary bit 7.
- R10: In a data phase, each data-register read (data-in) or write (data-out) pulses tgt_xfer_o. A read returns tgt_din_i and keeps it in the data register; a write presents the byte on tgt_dout_o. Each such access decrements the transfer count and the block counter. When the block counter empties, tgt_next_o pulses and tgt_blk_len_i is sampled. A nonzero length starts a new block. A zero length stores tgt_status_i into index 0x0F, sets status 0x16 and disconnects.
- R11: A general register write takes effect only at index 0x16 or below. At any other general index the write is dropped, but the index still increments.
- R12: Any other command code, including 0x02, only records the code in index 0x18.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_rd | input | 1 | Host read strobe, one cycle per access |
| host_wr | input | 1 | Host write strobe, one cycle per access |
| host_addr | input | 1 | 0 = address location / auxiliary status, 1 = data location |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data, valid while host_rd is high |
| own_id_o | output | 3 | Controller's own bus ID |
| tgt_sel_o | output | 1 | Select strobe to the target |
| tgt_id_o | output | 3 | Target ID |
| tgt_msg_vld_o | output | 1 | Identify message valid |
| tgt_msg_o | output | 8 | Identify message byte |
| tgt_accept_i | input | 1 | Target accepts the selection |
| tgt_phase_i | input | 2 | Phase returned by the target |
| tgt_blk_len_i | input | 8 | Block length at select or next-block request; 0 = no more data |
| tgt_status_i | input | 8 | Target status byte |
| tgt_next_o | output | 1 | Next-block request |
| tgt_xfer_o | output | 1 | One data byte moved |
| tgt_dout_o | output | 8 | Data-out byte to the target |
| tgt_din_i | input | 8 | Data-in byte from the target |

## Verification
A wrong index shows up on the very next data-location access: the host reads or writes a different register than it expects. Reading a known value back therefore exposes a bad increment or a missing hold within one access. A corrupted phase or block counter shows up as a tgt_xfer_o pulse that does not come, or as a next-block request on the wrong byte. It also shows up as an auxiliary status that still reads 0x31 after the last byte, when it should read 0x80. A lost command-in-progress flag lets a second command overwrite index 0x18, which the next read of that index reveals.

// File: rtl/scsi_hostif_pkg.sv
package scsi_hostif_pkg;
  localparam int AW = 5;
  localparam int DW = 8;

  localparam logic [AW-1:0] IX_OWN   = 5'h00;
  localparam logic [AW-1:0] IX_TLUN  = 5'h0F;
  localparam logic [AW-1:0] IX_TCH   = 5'h12;
  localparam logic [AW-1:0] IX_TCM   = 5'h13;
  localparam logic [AW-1:0] IX_TCL   = 5'h14;
  localparam logic [AW-1:0] IX_DST   = 5'h15;
  localparam logic [AW-1:0] IX_SRC   = 5'h16;
  localparam logic [AW-1:0] IX_STAT  = 5'h17;
  localparam logic [AW-1:0] IX_CMD   = 5'h18;
  localparam logic [AW-1:0] IX_DATA  = 5'h19;
  localparam logic [AW-1:0] IX_CLRHI = 5'h1A;
  localparam logic [AW-1:0] IX_AUX   = 5'h1F;

  localparam logic [DW-1:0] ST_RESET     = 8'h00;
  localparam logic [DW-1:0] ST_RESET_ADV = 8'h01;
  localparam logic [DW-1:0] ST_SEL_TO    = 8'h42;
  localparam logic [DW-1:0] ST_XFER_END  = 8'h16;
  localparam logic [DW-1:0] ST_DISC      = 8'h85;

  localparam int AUX_INT = 7;
  localparam int AUX_BSY = 5;
  localparam int AUX_CIP = 4;
  localparam int AUX_DBR = 0;
  localparam int OWN_ADV = 3;

  localparam logic [DW-1:0] AUX_ONLY_INT = 8'h80;
  localparam logic [DW-1:0] AUX_XFER     = 8'h31;

  typedef enum logic [1:0] {PH_IDLE = 2'd0, PH_DIN = 2'd1, PH_DOUT = 2'd2} xfer_ph_e;
endpackage

// File: rtl/scsi_hostif_latch.sv
module scsi_hostif_latch #(
  parameter int AW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          zero_i,
  input  logic          load_i,
  input  logic [AW-1:0] load_val_i,
  input  logic          inc_i,
  output logic [AW-1:0] idx_o
);
  logic [AW-1:0] idx_q, idx_n;

  always_comb begin
    idx_n = idx_q;
    if (zero_i)      idx_n = '0;
    else if (load_i) idx_n = load_val_i;
    else if (inc_i)  idx_n = idx_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) idx_q <= '0;
    else if (zero_i || load_i || inc_i) idx_q <= idx_n;
  end

  assign idx_o = idx_q;
endmodule

// File: rtl/scsi_hostif_tc.sv
module scsi_hostif_tc #(
  parameter int TCW = 24,
  parameter int DW  = 8,
  localparam int NB = TCW / DW,
  localparam int LW = (NB > 1) ? $clog2(NB) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           clr_i,
  input  logic           wr_i,
  input  logic [LW-1:0]  lane_i,
  input  logic [DW-1:0]  wdata_i,
  input  logic           dec_i,
  output logic [TCW-1:0] cnt_o
);
  logic [TCW-1:0] cnt_q, cnt_n, cnt_wr;

  for (genvar g = 0; g < NB; g++) begin : g_lane
    assign cnt_wr[g*DW +: DW] = (wr_i && lane_i == LW'(g)) ? wdata_i : cnt_q[g*DW +: DW];
  end

  always_comb begin
    cnt_n = cnt_q;
    if (clr_i)      cnt_n = '0;
    else if (wr_i)  cnt_n = cnt_wr;
    else if (dec_i) cnt_n = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else if (clr_i || wr_i || dec_i) cnt_q <= cnt_n;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/scsi_hostif.sv
module scsi_hostif
  import scsi_hostif_pkg::*;
#(
  parameter int TCW     = 24,
  parameter int BLKW    = 8,
  parameter int MAX_DEV = 7
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        host_rd,
  input  logic        host_wr,
  input  logic        host_addr,
  input  logic [7:0]  host_wdata,
  output logic [7:0]  host_rdata,
  output logic [2:0]  own_id_o,
  output logic        tgt_sel_o,
  output logic [2:0]  tgt_id_o,
  output logic        tgt_msg_vld_o,
  output logic [7:0]  tgt_msg_o,
  input  logic        tgt_accept_i,
  input  logic [1:0]  tgt_phase_i,
  input  logic [7:0]  tgt_blk_len_i,
  input  logic [7:0]  tgt_status_i,
  output logic        tgt_next_o,
  output logic        tgt_xfer_o,
  output logic [7:0]  tgt_dout_o,
  input  logic [7:0]  tgt_din_i
);
  localparam int NREG = 1 << AW;
  localparam int NB   = TCW / DW;
  localparam int LW   = (NB > 1) ? $clog2(NB) : 1;

  logic [DW-1:0]   regs_q [NREG];
  logic [DW-1:0]   regs_n [NREG];
  logic [DW-1:0]   aux_q, aux_n;
  xfer_ph_e        ph_q, ph_n;
  logic            busy_q, busy_n;
  logic [BLKW-1:0] blk_q, blk_n;
  logic [2:0]      tid_q, tid_n, own_q, own_n;
  logic [AW-1:0]   idx;
  logic            lat_zero, lat_load, lat_inc;
  logic            tc_clr, tc_wr, tc_dec;
  logic [LW-1:0]   tc_lane;
  logic [TCW-1:0]  tc_cnt;
  logic            wr_dp, rd_dp, do_disc, step, cmd_ok, sel_ok;
  logic [DW-1:0]   cmd_reg, stat_reg;

  assign wr_dp    = host_wr && host_addr;
  assign rd_dp    = host_rd && host_addr && !host_wr;
  assign cmd_ok   = wr_dp && idx == IX_CMD && !aux_q[AUX_CIP];
  assign sel_ok   = !busy_q && (int'(regs_q[IX_DST][2:0]) < MAX_DEV);
  assign tc_lane  = (idx == IX_TCL) ? LW'(0) : (idx == IX_TCM) ? LW'(1) : LW'(2);
  assign cmd_reg  = regs_q[IX_CMD];
  assign stat_reg = regs_q[IX_STAT];

  scsi_hostif_latch #(.AW(AW)) u_latch (
    .clk(clk), .rst_n(rst_n), .zero_i(lat_zero), .load_i(lat_load),
    .load_val_i(host_wdata[AW-1:0]), .inc_i(lat_inc), .idx_o(idx));

  scsi_hostif_tc #(.TCW(TCW), .DW(DW)) u_tc (
    .clk(clk), .rst_n(rst_n), .clr_i(tc_clr), .wr_i(tc_wr), .lane_i(tc_lane),
    .wdata_i(host_wdata), .dec_i(tc_dec), .cnt_o(tc_cnt));

  // read mux
  always_comb begin
    if (!host_addr)                               host_rdata = aux_q;
    else if (idx == IX_AUX)                       host_rdata = aux_q;
    else if (idx == IX_DATA && ph_q == PH_DIN)    host_rdata = tgt_din_i;
    else if (idx == IX_TCH || idx == IX_TCM || idx == IX_TCL)
                                                  host_rdata = tc_cnt[tc_lane*DW +: DW];
    else                                          host_rdata = regs_q[idx];
  end

  // next-state
  always_comb begin
    regs_n = regs_q;
    aux_n = aux_q; ph_n = ph_q; busy_n = busy_q; blk_n = blk_q;
    tid_n = tid_q; own_n = own_q;
    lat_zero = 1'b0; lat_load = host_wr && !host_addr; lat_inc = 1'b0;
    tc_clr = 1'b0; tc_wr = 1'b0; tc_dec = 1'b0;
    tgt_sel_o = 1'b0; tgt_msg_vld_o = 1'b0; tgt_next_o = 1'b0; tgt_xfer_o = 1'b0;
    do_disc = 1'b0; step = 1'b0;

    if (wr_dp) begin
      unique case (idx)
        IX_OWN: begin regs_n[IX_OWN] = host_wdata; own_n = host_wdata[2:0]; lat_inc = 1'b1; end
        IX_TCH, IX_TCM, IX_TCL: begin tc_wr = 1'b1; lat_inc = 1'b1; end
        IX_AUX: ;
        IX_DATA: begin
          regs_n[IX_DATA] = host_wdata;
          if (ph_q == PH_DOUT) step = 1'b1;
        end
        IX_CMD: if (cmd_ok) begin
          regs_n[IX_CMD] = host_wdata;
          case (host_wdata)
            8'h00: begin
              for (int i = 1; i <= int'(IX_CLRHI); i++) regs_n[i] = '0;
              do_disc = 1'b1; lat_zero = 1'b1; tc_clr = 1'b1;
              regs_n[IX_STAT] = regs_q[IX_OWN][OWN_ADV] ? ST_RESET_ADV : ST_RESET;
            end
            8'h04: do_disc = 1'b1;
            8'h06, 8'h07: begin
              tid_n = regs_q[IX_DST][2:0];
              regs_n[IX_STAT] = ST_SEL_TO; tc_clr = 1'b1; aux_n = AUX_ONLY_INT;
            end
            8'h08, 8'h09: begin
              tid_n = regs_q[IX_DST][2:0];
              tgt_sel_o = sel_ok;
              if (sel_ok && tgt_accept_i) begin
                tgt_msg_vld_o = (host_wdata == 8'h08);
                if (tgt_phase_i == 2'd1 || tgt_phase_i == 2'd2) begin
                  busy_n = 1'b1; aux_n = AUX_XFER; blk_n = tgt_blk_len_i;
                  ph_n = (tgt_phase_i == 2'd1) ? PH_DIN : PH_DOUT;
                end else begin
                  regs_n[IX_TLUN] = tgt_status_i; regs_n[IX_STAT] = ST_XFER_END;
                  do_disc = 1'b1;
                end
              end else begin
                regs_n[IX_STAT] = ST_SEL_TO; tc_clr = 1'b1; aux_n = AUX_ONLY_INT;
              end
            end
            default: ;
          endcase
        end
        default: begin
          if (idx <= IX_SRC) regs_n[idx] = host_wdata;
          lat_inc = 1'b1;
        end
      endcase
    end else if (rd_dp) begin
      unique case (idx)
        IX_STAT: begin
          lat_inc = 1'b1;
          if (stat_reg == ST_XFER_END) begin
            regs_n[IX_STAT] = ST_DISC; aux_n = AUX_ONLY_INT;
          end else aux_n[AUX_INT] = 1'b0;
        end
        IX_DATA: if (ph_q == PH_DIN) begin
          regs_n[IX_DATA] = tgt_din_i; step = 1'b1;
        end
        IX_CMD, IX_AUX: ;
        default: lat_inc = 1'b1;
      endcase
    end

    if (step) begin
      tgt_xfer_o = 1'b1; tc_dec = 1'b1;
      if (blk_q == BLKW'(1)) begin
        tgt_next_o = 1'b1;
        if (tgt_blk_len_i != '0) blk_n = tgt_blk_len_i;
        else begin
          blk_n = '0; regs_n[IX_TLUN] = tgt_status_i; regs_n[IX_STAT] = ST_XFER_END;
          do_disc = 1'b1;
        end
      end else blk_n = blk_q - 1'b1;
    end

    if (do_disc) begin
      ph_n = PH_IDLE; busy_n = 1'b0; aux_n = AUX_ONLY_INT;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) regs_q[i] <= '0;
      aux_q <= '0; ph_q <= PH_IDLE; busy_q <= 1'b0; blk_q <= '0;
      tid_q <= '0; own_q <= '0;
    end else if (host_rd || host_wr) begin
      regs_q <= regs_n;
      aux_q <= aux_n; ph_q <= ph_n; busy_q <= busy_n; blk_q <= blk_n;
      tid_q <= tid_n; own_q <= own_n;
    end
  end

  assign own_id_o   = own_q;
  assign tgt_id_o   = tid_n;
  assign tgt_msg_o  = regs_q[IX_TLUN] | 8'h80;
  assign tgt_dout_o = host_wdata;

  // R1: index holds at command, data and auxiliary entries
  p_latch_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (host_addr && (host_rd || host_wr) && (idx == IX_DATA || idx == IX_AUX ||
      (idx == IX_CMD && !(cmd_ok && host_wdata == 8'h00)))) |=> $stable(idx));

  // R4: command ignored while one is in progress
  p_cip_block_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_dp && idx == IX_CMD && aux_q[AUX_CIP]) |=> ($stable(cmd_reg) && $stable(aux_q)));

  // R6: plain select leaves a zero count
  p_tc_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_ok && (host_wdata == 8'h06 || host_wdata == 8'h07)) |=> (tc_cnt == '0));

  // R9: reading transfer-end moves to disconnect
  p_end_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_dp && idx == IX_STAT && stat_reg == ST_XFER_END) |=>
      (aux_q == AUX_ONLY_INT && stat_reg == ST_DISC));

  // R10: last block empty ends the data phase
  p_block_end_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (tgt_next_o && tgt_blk_len_i == '0) |=> (ph_q == PH_IDLE && aux_q == AUX_ONLY_INT));
endmodule

// File: tb/scsi_hostif_bench.sv
module scsi_hostif_bench;
  logic clk, rst_n, host_rd, host_wr, host_addr;
  logic [7:0] host_wdata, host_rdata;
  logic [2:0] own_id_o, tgt_id_o;
  logic tgt_sel_o, tgt_msg_vld_o, tgt_next_o, tgt_xfer_o;
  logic [7:0] tgt_msg_o, tgt_dout_o;
  logic tb_accept;
  logic [1:0] tb_phase;
  logic [7:0] tb_len, tb_status;
  int blocks_left, xfer_cnt, sel_cnt, msg_cnt;
  logic [7:0] last_msg, last_dout;
  int errors = 0, checks = 0;
  logic done = 1'b0;

  scsi_hostif u_scsi_hostif (
    .clk(clk), .rst_n(rst_n), .host_rd(host_rd), .host_wr(host_wr), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .own_id_o(own_id_o),
    .tgt_sel_o(tgt_sel_o), .tgt_id_o(tgt_id_o), .tgt_msg_vld_o(tgt_msg_vld_o),
    .tgt_msg_o(tgt_msg_o), .tgt_accept_i(tb_accept), .tgt_phase_i(tb_phase),
    .tgt_blk_len_i((blocks_left != 0) ? tb_len : 8'h00), .tgt_status_i(tb_status),
    .tgt_next_o(tgt_next_o), .tgt_xfer_o(tgt_xfer_o), .tgt_dout_o(tgt_dout_o),
    .tgt_din_i(8'hC0 + 8'(xfer_cnt)));

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // target model
  always @(posedge clk) begin
    if ((tgt_sel_o && tb_accept) || tgt_next_o)
      if (blocks_left > 0) blocks_left <= blocks_left - 1;
    if (tgt_sel_o) sel_cnt <= sel_cnt + 1;
    if (tgt_msg_vld_o) begin msg_cnt <= msg_cnt + 1; last_msg <= tgt_msg_o; end
    if (tgt_xfer_o) begin xfer_cnt <= xfer_cnt + 1; last_dout <= tgt_dout_o; end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic acc(input logic a, input logic w, input logic [7:0] d, output logic [7:0] r);
    @(negedge clk);
    host_addr = a; host_wr = w; host_rd = !w; host_wdata = d;
    #2 r = host_rdata;
    @(posedge clk); #1;
    host_rd = 1'b0; host_wr = 1'b0;
  endtask

  task automatic setidx(input logic [7:0] i); logic [7:0] r; acc(1'b0, 1'b1, i, r); endtask
  task automatic wd(input logic [7:0] d); logic [7:0] r; acc(1'b1, 1'b1, d, r); endtask
  task automatic rd(output logic [7:0] r); acc(1'b1, 1'b0, 8'h00, r); endtask
  task automatic raux(output logic [7:0] r); acc(1'b0, 1'b0, 8'h00, r); endtask
  task automatic rd_at(input logic [7:0] i, output logic [7:0] r); setidx(i); rd(r); endtask
  task automatic wr_at(input logic [7:0] i, input logic [7:0] d); setidx(i); wd(d); endtask

  task automatic t_reset_state;
    logic [7:0] r;
    raux(r); chk("R1 aux after reset", r, 8'h00);
    chk("R3 own id after reset", own_id_o, 0);
  endtask

  task automatic t_index_r1_r3_r11;
    logic [7:0] r;
    wr_at(8'h00, 8'h0D);
    chk("R3 own id", own_id_o, 5);
    wd(8'hAA); wd(8'hBB);              // indices 1, 2 by increment
    rd_at(8'h00, r); chk("R3 own reg", r, 8'h0D);
    rd(r); chk("R1 incr read 1", r, 8'hAA);
    rd(r); chk("R1 incr read 2", r, 8'hBB);
    wr_at(8'h16, 8'h33); wd(8'h55);    // 0x16 kept, 0x17 dropped
    rd_at(8'h16, r); chk("R11 idx 0x16 written", r, 8'h33);
    rd(r); chk("R11 idx 0x17 not written", r, 8'h00);
    wr_at(8'h1E, 8'h77); rd(r); chk("R1 aux via data at 0x1F", r, 8'h00);
    rd_at(8'h1E, r); chk("R11 idx 0x1E not written", r, 8'h00);
  endtask

  task automatic t_tc_r2;
    logic [7:0] r;
    setidx(8'h12); wd(8'h01); wd(8'h02); wd(8'h03);
    setidx(8'h13); wd(8'hFF);
    setidx(8'h12); rd(r); chk("R2 tc high", r, 8'h01);
    rd(r); chk("R2 tc mid replaced", r, 8'hFF);
    rd(r); chk("R2 tc low", r, 8'h03);
  endtask

  task automatic t_select_r6_r9_r12;
    logic [7:0] r;
    wr_at(8'h15, 8'h0B);
    wr_at(8'h18, 8'h06);
    chk("R6 target id", tgt_id_o, 3);
    raux(r); chk("R6 aux int", r, 8'h80);
    rd(r); chk("R1 cmd idx holds", r, 8'h06);
    rd_at(8'h14, r); chk("R6 tc cleared", r, 8'h00);
    rd_at(8'h17, r); chk("R6 sel timeout", r, 8'h42);
    raux(r); chk("R9 int cleared by status read", r, 8'h00);
    wr_at(8'h18, 8'h02);
    rd(r); chk("R12 code recorded", r, 8'h02);
    rd_at(8'h17, r); chk("R12 status unchanged", r, 8'h42);
    raux(r); chk("R12 aux unchanged", r, 8'h00);
    chk("R7 no select on plain select", sel_cnt, 0);
  endtask

  task automatic t_selxfer_fail_r7;
    logic [7:0] r;
    tb_accept = 1'b1; tb_phase = 2'd1;
    wr_at(8'h15, 8'h07); wr_at(8'h18, 8'h09);
    chk("R7 id at limit no select", sel_cnt, 0);
    raux(r); chk("R7 id at limit aux", r, 8'h80);
    rd_at(8'h17, r); chk("R7 id at limit status", r, 8'h42);
    tb_accept = 1'b0;
    wr_at(8'h15, 8'h02); wr_at(8'h18, 8'h09);
    chk("R7 select raised", sel_cnt, 1);
    raux(r); chk("R7 rejected aux", r, 8'h80);
    rd_at(8'h17, r); chk("R7 rejected status", r, 8'h42);
  endtask

  task automatic t_datain_r4_r8_r10;
    logic [7:0] r;
    int base;
    base = xfer_cnt;
    tb_accept = 1'b1; tb_phase = 2'd1; tb_len = 8'd2; tb_status = 8'h04; blocks_left = 2;
    wr_at(8'h0F, 8'h02); wr_at(8'h15, 8'h01);
    setidx(8'h12); wd(8'h00); wd(8'h00); wd(8'h04);
    wr_at(8'h18, 8'h08);
    chk("R8 identify sent", msg_cnt, 1);
    chk("R8 identify value", last_msg, 8'h82);
    raux(r); chk("R7 data phase aux", r, 8'h31);
    wr_at(8'h18, 8'h04);
    rd(r); chk("R4 cmd ignored", r, 8'h08);
    raux(r); chk("R4 aux kept", r, 8'h31);
    setidx(8'h19);
    for (int i = 0; i < 4; i++) begin
      rd(r); chk("R10 data-in byte", r, 8'hC0 + 8'(base + i));
      if (i == 2) begin raux(r); chk("R10 still in phase after 2nd block start", r, 8'h31); end
    end
    chk("R10 xfer pulses", xfer_cnt - base, 4);
    raux(r); chk("R10 disconnect aux", r, 8'h80);
    rd(r); chk("R10 data reg keeps last", r, 8'hC0 + 8'(base + 3));
    rd_at(8'h0F, r); chk("R10 target status stored", r, 8'h04);
    rd_at(8'h14, r); chk("R10 tc counted down", r, 8'h00);
    rd_at(8'h17, r); chk("R9 xfer end read", r, 8'h16);
    raux(r); chk("R9 aux exactly int", r, 8'h80);
    rd_at(8'h17, r); chk("R9 disconnect status", r, 8'h85);
    raux(r); chk("R9 int cleared", r, 8'h00);
  endtask

  task automatic t_dataout_r10;
    logic [7:0] r;
    int base, mbase;
    base = xfer_cnt; mbase = msg_cnt;
    tb_accept = 1'b1; tb_phase = 2'd2; tb_len = 8'd3; tb_status = 8'h00; blocks_left = 1;
    wr_at(8'h18, 8'h09);
    chk("R8 no identify without ATN", msg_cnt - mbase, 0);
    raux(r); chk("R7 data-out aux", r, 8'h31);
    setidx(8'h19); wd(8'h11); wd(8'h22);
    raux(r); chk("R10 mid block", r, 8'h31);
    wd(8'h33);
    chk("R10 data-out pulses", xfer_cnt - base, 3);
    chk("R10 data-out last byte", last_dout, 8'h33);
    raux(r); chk("R10 data-out end aux", r, 8'h80);
    rd_at(8'h17, r); chk("R10 data-out end status", r, 8'h16);
  endtask

  task automatic t_status_phase_r7;
    logic [7:0] r;
    tb_accept = 1'b1; tb_phase = 2'd0; tb_status = 8'h08;
    wr_at(8'h18, 8'h09);
    raux(r); chk("R7 status phase aux", r, 8'h80);
    rd_at(8'h0F, r); chk("R7 status phase lun reg", r, 8'h08);
    rd_at(8'h17, r); chk("R7 status phase status", r, 8'h16);
  endtask

  task automatic t_swreset_r5;
    logic [7:0] r;
    wr_at(8'h00, 8'h0D); wr_at(8'h01, 8'h5A);
    setidx(8'h14); wd(8'h05);
    wr_at(8'h18, 8'h00);
    raux(r); chk("R5 aux int", r, 8'h80);
    rd(r); chk("R5 index zeroed, own kept", r, 8'h0D);
    rd(r); chk("R5 idx 1 cleared", r, 8'h00);
    rd_at(8'h14, r); chk("R5 tc cleared", r, 8'h00);
    rd_at(8'h17, r); chk("R5 advanced reset code", r, 8'h01);
    wr_at(8'h00, 8'h05); wr_at(8'h18, 8'h00);
    rd_at(8'h17, r); chk("R5 plain reset code", r, 8'h00);
  endtask

  initial begin
    rst_n = 1'b0; host_rd = 1'b0; host_wr = 1'b0; host_addr = 1'b0; host_wdata = '0;
    tb_accept = 1'b0; tb_phase = 2'd0; tb_len = '0; tb_status = '0;
    blocks_left = 0; xfer_cnt = 0; sel_cnt = 0; msg_cnt = 0; last_msg = '0; last_dout = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    t_reset_state();
    t_index_r1_r3_r11();
    t_tc_r2();
    t_select_r6_r9_r12();
    t_selxfer_fail_r7();
    t_datain_r4_r8_r10();
    t_dataout_r10();
    t_status_phase_r7();
    t_swreset_r5();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule